// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in memory. A requester presents one virtual address together with an access kind (read, write or execute). The walker fetches the entry from the top-level directory. When that entry is valid, it fetches the entry from the leaf table that the directory entry points to. The leaf entry is then checked for validity and permission. The walker returns either the translated address or a fault code.

The directory's physical base and the number of directory slots a program may use are held in two configuration registers. Privileged software loads them through a small write port. Memory is reached through a request/response port, which carries word reads and, when needed, one write of the updated leaf entry. The block serves one translation at a time. Translation caching and the final data access are left to the surrounding logic.

Top module: `ptw_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0. Both configuration registers reset to 0.
- R2: The virtual address splits as follows: bits 31:22 are the directory index, bits 21:13 are the leaf index and bits 12:0 are the byte offset (8 KB pages). The directory entry is read at base + 4*dir_index. The leaf entry is read at {dir_entry[31:11], 11'b0} + 4*leaf_index. A successful result is the leaf frame field (entry bits 31:13) concatenated with the 13-bit offset, reported with fault code 0.
- R3: A directory index greater than or equal to the length register gives fault code 1. No memory request is issued for that walk.
- R4: A directory entry with bit 0 clear gives fault code 2. The walk issues exactly one memory read.
- R5: A leaf entry with bit 0 (valid) clear gives fault code 3, whatever its other bits hold.
- R6: Leaf permission bits are read = bit 3, write = bit 4 and execute = bit 5. Access codes are 0 read, 1 write and 2 execute. If the bit for the requested access is clear, or the access code is 3, the result is fault code 4. Permission is judged only from the leaf entry.
- R7: On success, the leaf entry gains the referenced bit (bit 1). A write access also gains the dirty bit (bit 2). The updated entry is written back to the same address only when this changes it, and a write counts as done once the memory port accepts it.
- R8: A walk starts when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` then stays low until the result has been presented. The result is a single-cycle `rsp_valid` pulse. `rsp_paddr` is 0 whenever the fault code is nonzero.
- R9: Configuration writes use `cfg_sel` to choose the register. With `cfg_sel` = 0, bits 31:12 of the data load the directory base and its low 12 bits read as zero. With `cfg_sel` = 1, bits 10:0 load the length. A write affects walks accepted after it.
- R10: Once raised, a memory request keeps its valid, address, write flag and data unchanged until `mem_req_ready` accepts it. Read data is taken on the first cycle `mem_rsp_valid` is high after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects directory base, 1 selects length |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for entry write-back, 0 for read |
| mem_req_addr | output | 32 | Physical word address of the table entry |
| mem_req_wdata | output | 32 | Updated leaf entry for write-back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned table entry |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 3 | 0 ok, 1 length, 2 directory invalid, 3 leaf invalid, 4 permission |

## Verification
The bench aims at the boundaries of the length register. The directory index equal to the length must fault with no read. The top index 1023 must pass the length test once the length is 1024. An off-by-one compare would either leak a read or wrongly reject the highest slot. A leaf entry with every bit set except valid checks that a design which trusts stale permission bits is caught. Repeat accesses to entries that already carry referenced and dirty bits check that no needless write-back is issued. A design that writes back on every hit would show extra memory writes. The memory ready line stalls in a pseudo-random pattern, so that a request which drifts or drops before acceptance, or a response taken from a stale cycle, shows up as a wrong address or a wrong result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_LEN  = 3'd1,
    FLT_DIR  = 3'd2,
    FLT_LEAF = 3'd3,
    FLT_PERM = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_WBACK,
    ST_DONE
  } wstate_e;

  // Entry field positions shared by directory and leaf entries
  localparam int E_VALID = 0;
  localparam int E_REF   = 1;
  localparam int E_DIRTY = 2;
  localparam int E_RD    = 3;
  localparam int E_WR    = 4;
  localparam int E_EX    = 5;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ptw_cfg_regs.sv
module ptw_cfg_regs #(
  parameter int AW   = 32,
  parameter int L1_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-L1_W-3:0] base_o,
  output logic [L1_W:0]     len_o
);
  localparam int BASE_LSB = L1_W + 2;

  logic [AW-BASE_LSB-1:0] base_q, base_d;
  logic [L1_W:0]          len_q, len_d;
  logic                   base_en, len_en;
  logic                   cfg_unused;

  always_comb begin
    base_en = cfg_we && !cfg_sel;
    len_en  = cfg_we &&  cfg_sel;
    base_d  = cfg_wdata[AW-1:BASE_LSB];
    len_d   = cfg_wdata[L1_W:0];
  end

  assign cfg_unused = cfg_wdata[L1_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (len_en)  len_q  <= len_d;
    end
  end

  assign base_o = base_q;
  assign len_o  = len_q;

  // R9
  len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (len_o == $past(cfg_wdata[L1_W:0])));
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 13
) (
  input  logic [AW-1:0]       pte,
  input  acc_e                acc,
  output fault_e              fault,
  output logic [AW-OFF_W-1:0] frame,
  output logic [AW-1:0]       pte_new,
  output logic                wb_need
);
  logic perm_ok;
  logic [AW-1:0] set_mask;

  always_comb begin
    unique case (acc)
      ACC_READ:  perm_ok = pte[E_RD];
      ACC_WRITE: perm_ok = pte[E_WR];
      ACC_EXEC:  perm_ok = pte[E_EX];
      default:   perm_ok = 1'b0;
    endcase

    if (!pte[E_VALID])  fault = FLT_LEAF;
    else if (!perm_ok)  fault = FLT_PERM;
    else                fault = FLT_NONE;

    set_mask          = '0;
    set_mask[E_REF]   = 1'b1;
    set_mask[E_DIRTY] = (acc == ACC_WRITE);
    pte_new           = pte | set_mask;
    wb_need           = (fault == FLT_NONE) && (pte_new != pte);
    frame             = pte[AW-1:OFF_W];
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int L1_W  = 10,
  parameter int L2_W  = 9,
  parameter int OFF_W = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-L1_W-3:0]    base_i,
  input  logic [L1_W:0]         len_i,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AW-1:0]         req_vaddr,
  input  logic [1:0]            req_acc,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_we,
  output logic [AW-1:0]         mem_req_addr,
  output logic [AW-1:0]         mem_req_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [AW-1:0]         mem_rsp_data,
  output logic                  rsp_valid,
  output logic [AW-1:0]         rsp_paddr,
  output logic [2:0]            rsp_fault
);
  localparam int LOW_W   = L2_W + OFF_W;
  localparam int LEAF_AL = L2_W + 2;

  wstate_e             state_q, state_d;
  logic [LOW_W-1:0]    vlow_q;
  acc_e                acc_q;
  logic [AW-1:0]       addr_q, addr_d, wdata_q, wdata_d, paddr_q, paddr_d;
  fault_e              fault_q, fault_d;
  logic vlow_en, acc_en, addr_en, wdata_en, fault_en, paddr_en;

  logic [L1_W-1:0]     req_idx1;
  logic [L2_W-1:0]     idx2;
  logic [OFF_W-1:0]    offs;

  fault_e              ev_fault;
  logic [AW-OFF_W-1:0] ev_frame;
  logic [AW-1:0]       ev_pte_new;
  logic                ev_wb;

  assign req_idx1 = req_vaddr[AW-1 -: L1_W];
  assign idx2     = vlow_q[OFF_W +: L2_W];
  assign offs     = vlow_q[OFF_W-1:0];

  ptw_pte_eval #(.AW(AW), .OFF_W(OFF_W)) u_eval (
    .pte     (mem_rsp_data),
    .acc     (acc_q),
    .fault   (ev_fault),
    .frame   (ev_frame),
    .pte_new (ev_pte_new),
    .wb_need (ev_wb)
  );

  always_comb begin
    state_d  = state_q;
    vlow_en  = 1'b0;
    acc_en   = 1'b0;
    addr_d   = addr_q;
    addr_en  = 1'b0;
    wdata_d  = ev_pte_new;
    wdata_en = 1'b0;
    fault_d  = fault_q;
    fault_en = 1'b0;
    paddr_d  = paddr_q;
    paddr_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        vlow_en  = 1'b1;
        acc_en   = 1'b1;
        paddr_en = 1'b1;
        paddr_d  = '0;
        fault_en = 1'b1;
        if ({1'b0, req_idx1} >= len_i) begin
          fault_d = FLT_LEN;
          state_d = ST_DONE;
        end else begin
          fault_d = FLT_NONE;
          addr_en = 1'b1;
          addr_d  = {base_i, req_idx1, 2'b00};
          state_d = ST_DIR_REQ;
        end
      end
      ST_DIR_REQ:  if (mem_req_ready) state_d = ST_DIR_WAIT;
      ST_DIR_WAIT: if (mem_rsp_valid) begin
        if (!mem_rsp_data[E_VALID]) begin
          fault_en = 1'b1;
          fault_d  = FLT_DIR;
          state_d  = ST_DONE;
        end else begin
          addr_en = 1'b1;
          addr_d  = {mem_rsp_data[AW-1:LEAF_AL], idx2, 2'b00};
          state_d = ST_LEAF_REQ;
        end
      end
      ST_LEAF_REQ:  if (mem_req_ready) state_d = ST_LEAF_WAIT;
      ST_LEAF_WAIT: if (mem_rsp_valid) begin
        fault_en = 1'b1;
        fault_d  = ev_fault;
        if (ev_fault != FLT_NONE) begin
          state_d = ST_DONE;
        end else begin
          paddr_en = 1'b1;
          paddr_d  = {ev_frame, offs};
          if (ev_wb) begin
            wdata_en = 1'b1;
            state_d  = ST_WBACK;
          end else begin
            state_d  = ST_DONE;
          end
        end
      end
      ST_WBACK: if (mem_req_ready) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vlow_q  <= '0;
      acc_q   <= ACC_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else begin
      state_q <= state_d;
      if (vlow_en)  vlow_q  <= req_vaddr[LOW_W-1:0];
      if (acc_en)   acc_q   <= acc_e'(req_acc);
      if (addr_en)  addr_q  <= addr_d;
      if (wdata_en) wdata_q <= wdata_d;
      if (fault_en) fault_q <= fault_d;
      if (paddr_en) paddr_q <= paddr_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_LEAF_REQ) ||
                         (state_q == ST_WBACK);
  assign mem_req_we    = (state_q == ST_WBACK);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;

  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) &&
       $stable(mem_req_wdata)));

  // R4
  dir_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIR_WAIT && mem_rsp_valid && !mem_rsp_data[E_VALID]) |=>
      (rsp_valid && rsp_fault == FLT_DIR && !mem_req_valid));

  // R7
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (mem_req_wdata[E_REF] && mem_req_wdata[E_VALID]));
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter int AW         = 32,
  parameter int L1_W       = 10,
  parameter int L2_W       = 9,
  parameter int OFF_W      = 13,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_acc,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [AW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic [2:0]    rsp_fault
);
  logic                 rst_n_s;
  logic [AW-L1_W-3:0]   base_w;
  logic [L1_W:0]        len_w;

  ptw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ptw_cfg_regs #(.AW(AW), .L1_W(L1_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_o    (base_w),
    .len_o     (len_w)
  );

  ptw_walk_fsm #(.AW(AW), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .base_i        (base_w),
    .len_i         (len_w),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_acc       (req_acc),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault)
  );
endmodule

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV         = 12;
  localparam int WD_CYCLES  = 50000;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [2:0]  flt;
    logic [31:0] pa;
    logic [1:0]  nrd;
    logic        wb;
    logic [31:0] wdat;
  } vec_t;

  // base 0, length 4; directory at 0x0, leaf tables at 0x800 and 0x1000
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1ABC, 2'd0, 3'd0, 32'h2468_BABC, 2'd2, 1'b1, 32'h2468_A00B},
    '{32'h0000_0010, 2'd1, 3'd4, 32'h0000_0000, 2'd2, 1'b0, 32'h0},
    '{32'h0000_2000, 2'd0, 3'd3, 32'h0000_0000, 2'd2, 1'b0, 32'h0},
    '{32'h0040_0000, 2'd0, 3'd2, 32'h0000_0000, 2'd1, 1'b0, 32'h0},
    '{32'h0100_0000, 2'd0, 3'd1, 32'h0000_0000, 2'd0, 1'b0, 32'h0},
    '{32'h0000_4000, 2'd1, 3'd0, 32'h0008_4000, 2'd2, 1'b0, 32'h0},
    '{32'h0000_7FFF, 2'd2, 3'd0, 32'hFFFF_FFFF, 2'd2, 1'b1, 32'hFFFF_E023},
    '{32'h0000_6000, 2'd0, 3'd4, 32'h0000_0000, 2'd2, 1'b0, 32'h0},
    '{32'h00BF_E005, 2'd1, 3'd0, 32'h0000_2005, 2'd2, 1'b1, 32'h0000_201F},
    '{32'h00BF_E000, 2'd0, 3'd0, 32'h0000_2000, 2'd2, 1'b0, 32'h0},
    '{32'h0000_4000, 2'd3, 3'd4, 32'h0000_0000, 2'd2, 1'b0, 32'h0},
    '{32'h00C0_0000, 2'd0, 3'd0, 32'h2468_A000, 2'd2, 1'b0, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;

  logic        ld_we;
  logic [10:0] ld_idx;
  logic [31:0] ld_dat;

  logic [31:0] mem [2048];
  logic [7:0]  lfsr;
  int          rd_cnt, wr_cnt;
  logic [31:0] last_wdata;
  logic        hold_bad;
  logic        prev_pend;
  logic [31:0] prev_addr;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  assign mem_req_ready = lfsr[0] | lfsr[3];

  // memory model: one-cycle read latency, stalls from an LFSR
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr          <= 8'hA5;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      rd_cnt        <= 0;
      wr_cnt        <= 0;
      last_wdata    <= '0;
      hold_bad      <= 1'b0;
      prev_pend     <= 1'b0;
      prev_addr     <= '0;
    end else begin
      lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rsp_valid <= 1'b0;
      if (ld_we) mem[ld_idx] <= ld_dat;
      if (prev_pend && (!mem_req_valid || mem_req_addr != prev_addr)) hold_bad <= 1'b1;
      prev_pend <= mem_req_valid && !mem_req_ready;
      prev_addr <= mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr[12:2]] <= mem_req_wdata;
          wr_cnt     <= wr_cnt + 1;
          last_wdata <= mem_req_wdata;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr[12:2]];
          rd_cnt        <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string ftag(input logic [2:0] f);
    case (f)
      3'd1:    return "R3 length fault";
      3'd2:    return "R4 directory invalid";
      3'd3:    return "R5 leaf invalid";
      3'd4:    return "R6 permission";
      default: return "R2 translation";
    endcase
  endfunction

  task automatic load(input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_idx = idx[10:0]; ld_dat = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic cfg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc,
                      output logic [2:0] flt, output logic [31:0] pa,
                      output int nrd, output int nwr, output logic [31:0] wd);
    int r0, w0, guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    req_valid = 1'b1; req_vaddr = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready || rsp_valid == 1'b0 && req_ready == 1'b0, "R8 busy after accept", {31'b0, req_ready}, 32'h0);
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    flt = rsp_fault; pa = rsp_paddr;
    nrd = rd_cnt - r0; nwr = wr_cnt - w0; wd = last_wdata;
    chk(guard < 200, "R8 result returned", guard, 32'd200);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 single pulse then ready", {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=done", WD_CYCLES);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [2:0]  f;
    logic [31:0] p, w;
    int nr, nw;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0; req_acc = '0;
    ld_we = 1'b0; ld_idx = '0; ld_dat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state at the ports
    chk(req_ready == 1'b1, "R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);

    // R1 reset length is zero: index 0 faults with no read
    walk(32'h0, 2'd0, f, p, nr, nw, w);
    chk(f == 3'd1 && nr == 0, "R1 length zero after reset", {29'b0, f}, 32'h1);

    for (int i = 0; i < 2048; i++) load(i, 32'h0);
    load(0, 32'h0000_0801);
    load(1, 32'hFFFF_F800);
    load(2, 32'h0000_1001);
    load(3, 32'h0000_0801);
    load(512, 32'h2468_A009);
    load(513, 32'hFFFF_FFFE);
    load(514, 32'h0008_401F);
    load(515, 32'hFFFF_E021);
    load(1535, 32'h0000_2019);
    cfg(1'b0, 32'h0000_0000);
    cfg(1'b1, 32'h0000_0004);

    for (int i = 0; i < NV; i++) begin
      walk(VECS[i].va, VECS[i].acc, f, p, nr, nw, w);
      chk(f == VECS[i].flt, ftag(VECS[i].flt), {29'b0, f}, {29'b0, VECS[i].flt});
      chk(p == VECS[i].pa, "R2 physical address", p, VECS[i].pa);
      chk(nr == int'(VECS[i].nrd), "R2 read count", nr, {30'b0, VECS[i].nrd});
      chk(nw == int'(VECS[i].wb), "R7 write-back count", nw, {31'b0, VECS[i].wb});
      if (VECS[i].wb) chk(w == VECS[i].wdat, "R7 write-back data", w, VECS[i].wdat);
    end

    // R3 boundary: length 1023 rejects index 1023 with no read
    cfg(1'b1, 32'h0000_03FF);
    walk(32'hFFC0_0000, 2'd0, f, p, nr, nw, w);
    chk(f == 3'd1 && nr == 0, "R3 index equals length", {29'b0, f}, 32'h1);
    // R4/R9: length 1024 admits index 1023, invalid directory entry, one read
    cfg(1'b1, 32'h0000_0400);
    walk(32'hFFC0_0000, 2'd0, f, p, nr, nw, w);
    chk(f == 3'd2, "R4 top index directory invalid", {29'b0, f}, 32'h2);
    chk(nr == 1, "R4 single read", nr, 32'h1);
    // R9: base low bits dropped; R7: no write-back when bits already set
    cfg(1'b0, 32'h0000_0FFF);
    walk(32'h0000_1ABC, 2'd0, f, p, nr, nw, w);
    chk(f == 3'd0 && p == 32'h2468_BABC, "R9 base low bits ignored", p, 32'h2468_BABC);
    chk(nw == 0, "R7 no redundant write-back", nw, 32'h0);
    // R9 length change applies to later walks
    cfg(1'b1, 32'h0000_0000);
    walk(32'h0000_1ABC, 2'd0, f, p, nr, nw, w);
    chk(f == 3'd1 && p == 32'h0, "R9 new length applied", {29'b0, f}, 32'h1);

    chk(!hold_bad, "R10 request held while stalled", {31'b0, hold_bad}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule